// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Register File

This block is a memory-mapped GPIO controller organised as a parameterised number of 32-pin banks, with up to eight banks. Each pin has its own control word, which holds its direction and its edge-trigger type. Each bank has a set of 32-bit registers:

- an output latch, driven only through separate write-1-to-set and write-1-to-clear addresses;
- a read-only view of the synchronised pad inputs;
- a sticky edge-status register, cleared by writing 1s;
- an interrupt mask, with one address that sets mask bits and another that clears them.

Every bank drives its own interrupt line. The line is high while the bank has any status bit that is not masked.

Pad inputs pass through a two-flop synchroniser, and edges are detected on the synchronised value. The inputs are expected to be already filtered by a separate debounce stage. A separate lock controller provides one lock bit per pin. Any write aimed at a locked pin is dropped: this covers its control word and its bit in every bank register. Reads are registered: data appears one cycle after the read strobe, together with a valid flag.

Top module: `gpio_bank_regs`

## Requirements
- R1: The control word of pin p is at byte address 0x100+4p. Bit 0 is direction (1 = input, 0 = output) and bits [4:3] are the trigger code. Reads return only these bits, with all others zero. `pad_oe[p]` is the inverse of the direction bit.
- R2: For bank b, writing 0x40+4b sets the output latch bits where the data is 1, and writing 0x60+4b clears them. Zero data bits leave the latch unchanged. 0x00+4b reads the latch, which drives `pad_out`.
- R3: 0x20+4b reads the pad inputs after a two-flop synchroniser. A pad change is not visible to a read captured on the first or second rising edge after it, and is visible on the third.
- R4: The trigger code selects the edges detected on the synchronised input: 1 = rising, 2 = falling, 3 = both, 0 = none. A detected edge sets the pin's bit in the status register at 0x80+4b, three clock edges after the pad change.
- R5: A status bit latches whether or not the pin is masked. It is cleared only by writing 1 to it. An edge that arrives in the same cycle as its clear leaves the bit set.
- R6: Writing 1s to 0xA0+4b sets mask bits, and writing 1s to 0xC0+4b clears them. Both addresses read the current mask.
- R7: `bank_irq[b]` is high exactly when (status AND NOT mask) of bank b is nonzero.
- R8: While `pin_lock[p]` is 1, writes leave pin p's control word and its output, status and mask bits unchanged.
- R9: After reset, all mask bits are 1, all status and output bits are 0, and all pins are inputs with trigger code 0.
- R10: `bus_rdata` and `bus_rvalid` update one cycle after `bus_re`. Read data holds between reads. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | BANK_PINS | Write data |
| bus_rdata | output | BANK_PINS | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| pin_lock | input | NUM_BANKS*BANK_PINS | Per-pin write lock from the lock controller |
| pad_in | input | NUM_BANKS*BANK_PINS | Debounced pad inputs |
| pad_out | output | NUM_BANKS*BANK_PINS | Output latch |
| pad_oe | output | NUM_BANKS*BANK_PINS | Output enable, high for output pins |
| bank_irq | output | NUM_BANKS | Per-bank interrupt |

## Verification
Edge detection is exercised with rising, falling and both-edge trigger codes, and with code 0. Each pattern applies both edge directions, so a detector that ignores the code, or swaps rising and falling, reads back a wrong status. A clear write is placed in the exact cycle an edge lands, which distinguishes clear-wins from edge-wins. Reads taken one and two edges after a pad change separate a correct two-flop delay from a shorter one. Mask, lock and output-latch tests each use zero data bits, so a design that writes whole words instead of single bits is caught.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_PINS = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_we,
  input  logic                           bus_re,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [BANK_PINS-1:0]           bus_wdata,
  output logic [BANK_PINS-1:0]           bus_rdata,
  output logic                           bus_rvalid,
  input  logic [NUM_BANKS*BANK_PINS-1:0] pin_lock,
  input  logic [NUM_BANKS*BANK_PINS-1:0] pad_in,
  output logic [NUM_BANKS*BANK_PINS-1:0] pad_out,
  output logic [NUM_BANKS*BANK_PINS-1:0] pad_oe,
  output logic [NUM_BANKS-1:0]           bank_irq
);
  localparam int NP       = NUM_BANKS * BANK_PINS;
  localparam int CTL_BASE = 'h100;
  localparam int CTL_END  = CTL_BASE + 4 * NP;

  logic [NP-1:0] dir_q, out_q, st_q, mask_q;
  logic [NP-1:0] sy1, sy2, sy3;
  logic [1:0]    trig_q [NP];
  logic [NP-1:0] set_v, clr_v, stc_v, msk_v, umsk_v, hit;

  logic [ADDR_W-1:0] ctl_off;
  logic              ctl_hit, bank_hit;
  int                ctl_pin, bnk;
  logic [2:0]        grp;
  logic [BANK_PINS-1:0] rd_mux;

  assign ctl_off  = bus_addr - ADDR_W'(CTL_BASE);
  assign ctl_pin  = int'(ctl_off >> 2);
  assign ctl_hit  = (int'(bus_addr) >= CTL_BASE) && (int'(bus_addr) < CTL_END) && (bus_addr[1:0] == 2'b00);
  assign grp      = bus_addr[7:5];
  assign bnk      = int'(bus_addr[4:2]);
  assign bank_hit = (bus_addr[ADDR_W-1:8] == '0) && (bnk < NUM_BANKS) && (bus_addr[1:0] == 2'b00);

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;

  always_comb begin
    set_v = '0; clr_v = '0; stc_v = '0; msk_v = '0; umsk_v = '0;
    if (bus_we && bank_hit) begin
      case (grp)
        3'd2: set_v [bnk*BANK_PINS +: BANK_PINS] = bus_wdata;
        3'd3: clr_v [bnk*BANK_PINS +: BANK_PINS] = bus_wdata;
        3'd4: stc_v [bnk*BANK_PINS +: BANK_PINS] = bus_wdata;
        3'd5: msk_v [bnk*BANK_PINS +: BANK_PINS] = bus_wdata;
        3'd6: umsk_v[bnk*BANK_PINS +: BANK_PINS] = bus_wdata;
        default: ;
      endcase
    end
    set_v  &= ~pin_lock;
    clr_v  &= ~pin_lock;
    stc_v  &= ~pin_lock;
    msk_v  &= ~pin_lock;
    umsk_v &= ~pin_lock;
  end

  for (genvar i = 0; i < NP; i++) begin : g_edge
    assign hit[i] = (trig_q[i][0] & sy2[i] & ~sy3[i]) | (trig_q[i][1] & ~sy2[i] & sy3[i]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
    assign bank_irq[b] = |(st_q[b*BANK_PINS +: BANK_PINS] & ~mask_q[b*BANK_PINS +: BANK_PINS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
      dir_q <= '1; out_q <= '0; st_q <= '0; mask_q <= '1;
      for (int i = 0; i < NP; i++) trig_q[i] <= 2'b00;
    end else begin
      sy1 <= pad_in; sy2 <= sy1; sy3 <= sy2;
      out_q  <= (out_q | set_v) & ~clr_v;
      st_q   <= (st_q & ~stc_v) | hit;
      mask_q <= (mask_q | msk_v) & ~umsk_v;
      if (bus_we && ctl_hit && !pin_lock[ctl_pin]) begin
        dir_q[ctl_pin]  <= bus_wdata[0];
        trig_q[ctl_pin] <= bus_wdata[4:3];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctl_hit) begin
      rd_mux[0]   = dir_q[ctl_pin];
      rd_mux[4:3] = trig_q[ctl_pin];
    end else if (bank_hit) begin
      case (grp)
        3'd0:      rd_mux = out_q [bnk*BANK_PINS +: BANK_PINS];
        3'd1:      rd_mux = sy2   [bnk*BANK_PINS +: BANK_PINS];
        3'd4:      rd_mux = st_q  [bnk*BANK_PINS +: BANK_PINS];
        3'd5, 3'd6: rd_mux = mask_q[bnk*BANK_PINS +: BANK_PINS];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ((st_q & $past(st_q)) == $past(st_q)));
  a_r6_mask_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(mask_q));
  a_r2_out_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pad_out));
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata) && !bus_rvalid);
  a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> (bank_irq == '0));
endmodule

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic clk = 0, rst_n = 0, bus_we = 0, bus_re = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [NP-1:0] pin_lock = '0, pad_in = '0, pad_out, pad_oe;
  logic [NB-1:0] bank_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  gpio_bank_regs #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_lock(pin_lock), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .bank_irq(bank_irq));

  always @(negedge clk) begin
    if (bus_rvalid) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(3);
    // R9 reset state
    rd(12'h100, 32'h1, "R9 ctrl");
    rd(12'h0A0, 32'hFFFFFFFF, "R9 mask b0");
    rd(12'h0A4, 32'hFFFFFFFF, "R9 mask b1");
    rd(12'h080, 32'h0, "R9 status");
    chk(pad_oe, 64'h0, "R9 pad_oe");
    chk({62'h0, bank_irq}, 64'h0, "R9 irq");
    // R1 direction
    wr(12'h10C, 32'h0);
    chk(pad_oe, 64'h8, "R1 pad_oe");
    wr(12'h10C, 32'hFFFFFFE6);
    rd(12'h10C, 32'h0, "R1 readback masks other bits");
    // R2 set/clear
    wr(12'h040, 32'h9);
    rd(12'h000, 32'h9, "R2 set");
    chk({60'h0, pad_out[3:0]}, 64'h9, "R2 pad_out");
    wr(12'h060, 32'h1);
    rd(12'h000, 32'h8, "R2 clear");
    wr(12'h060, 32'h0);
    rd(12'h000, 32'h8, "R2 zero no effect");
    wr(12'h044, 32'h80000000);
    rd(12'h004, 32'h80000000, "R2 bank1");
    // R3 synchroniser delay
    pad_in[63:32] = 32'hA5;
    rd(12'h024, 32'h0, "R3 edge1");
    rd(12'h024, 32'h0, "R3 edge2");
    rd(12'h024, 32'hA5, "R3 edge3");
    // R4 rising, R5 masked latch, R6/R7
    wr(12'h100, 32'h9);
    pad_in[0] = 1; idle(3);
    rd(12'h080, 32'h1, "R4 rising");
    chk({62'h0, bank_irq}, 64'h0, "R5 masked no irq");
    wr(12'h0C0, 32'h1);
    chk({62'h0, bank_irq}, 64'h1, "R7 unmasked irq");
    rd(12'h0A0, 32'hFFFFFFFE, "R6 mask");
    rd(12'h0C0, 32'hFFFFFFFE, "R6 mask via clear addr");
    wr(12'h080, 32'h1);
    chk({62'h0, bank_irq}, 64'h0, "R5 cleared irq");
    rd(12'h080, 32'h0, "R5 cleared");
    pad_in[0] = 0; idle(3);
    rd(12'h080, 32'h0, "R4 rising ignores fall");
    // R4 falling
    wr(12'h100, 32'h11);
    pad_in[0] = 1; idle(3);
    rd(12'h080, 32'h0, "R4 falling ignores rise");
    pad_in[0] = 0; idle(3);
    rd(12'h080, 32'h1, "R4 falling");
    chk({62'h0, bank_irq}, 64'h1, "R7 irq falling");
    wr(12'h080, 32'h1);
    // R4 both
    wr(12'h108, 32'h19); wr(12'h0C0, 32'h4);
    pad_in[2] = 1; idle(3);
    rd(12'h080, 32'h4, "R4 both rise");
    wr(12'h080, 32'h4);
    pad_in[2] = 0; idle(3);
    rd(12'h080, 32'h4, "R4 both fall");
    wr(12'h080, 32'h4);
    // R4 code 0
    pad_in[4] = 1; idle(3);
    rd(12'h080, 32'h0, "R4 code0 none");
    // R5 edge beats clear
    pad_in[2] = 1; idle(3);
    pad_in[2] = 0; idle(2);
    wr(12'h080, 32'h4);
    rd(12'h080, 32'h4, "R5 edge wins over clear");
    wr(12'h080, 32'h4);
    rd(12'h080, 32'h0, "R5 later clear");
    // R6 mask set
    wr(12'h0A0, 32'h1);
    rd(12'h0A0, 32'hFFFFFFFB, "R6 mask set");
    // R8 lock
    pin_lock[5] = 1;
    wr(12'h040, 32'h20);
    rd(12'h000, 32'h8, "R8 locked out");
    wr(12'h114, 32'h0);
    rd(12'h114, 32'h1, "R8 locked ctrl");
    wr(12'h0C0, 32'h20);
    rd(12'h0A0, 32'hFFFFFFFB, "R8 locked mask");
    pin_lock[5] = 0;
    wr(12'h040, 32'h20);
    rd(12'h000, 32'h28, "R8 unlocked out");
    // R10 unmapped, R1 readback
    rd(12'h0E0, 32'h0, "R10 unmapped");
    rd(12'h108, 32'h19, "R1 ctrl readback");
    // R7 bank1
    wr(12'h180, 32'h9); wr(12'h0C4, 32'h1);
    pad_in[32] = 0; idle(3);
    pad_in[32] = 1; idle(3);
    chk({62'h0, bank_irq}, 64'h2, "R7 bank1 irq");
    rd(12'h084, 32'h1, "R4 bank1 status");
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule